// File: doc/BRIEF.md
# SCL Rate Generator

This block sets the pace of the clock line for a two-wire serial bus master. It works from the system clock. Software writes one configuration byte that holds a 7-bit divider code and a speed-mode bit. The block then drives an open-drain style clock: while the drive-low output is asserted the pad pulls the line low, and otherwise the line floats high.

Each line period has two parts. A low part comes first and a released part follows. The lengths of both parts come from one of two affine formulas, and the mode bit picks which formula is used. A one-cycle tick marks every rising edge of the line, so that a bit-level engine can sample data there.

The block paces the line only while the interface is enabled and a transfer is requested. In every other case the line is left released. The configuration byte keeps its value when the interface is disabled. A new configuration never alters a period that has already started.

Top module: `sclPacer`

## Requirements
- R1: With the mode bit at 0 (standard), each period has a low part of 2 × (code + 9) cycles followed by a released part of (code + 9) cycles.
- R2: With the mode bit at 1 (fast), the low part and the released part each last (code + 7) cycles.
- R3: In standard mode, a code of 0, 1 or 2 is treated as 3. This gives the floor values of 24 low cycles and 12 released cycles.
- R4: In fast mode, a code of 0 or 1 is treated as 2. This gives the floor values of 9 low cycles and 9 released cycles.
- R5: The configuration byte carries the divider code in bits 6..0 and the mode bit in bit 7. It is loaded on the clock edge where `cfgWe` is high, it resets to 00h, and it keeps its value whatever the levels of `enable` and `runReq`.
- R6: A configuration written during a period leaves that period's low and released lengths unchanged. The new lengths apply from the next period.
- R7: If `enable` or `runReq` is low at a clock edge, `sclDriveLow` is low and `bitTick` is low after that edge, and the phase counter is zero. When both inputs are high again, pacing restarts with a full low part one cycle later.
- R8: `bitTick` is high for exactly one cycle per period. That cycle is the first released cycle after a low part.
- R9: After reset, `sclDriveLow` and `bitTick` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Interface enable |
| runReq | input | 1 | Transfer request; the line is paced while this and `enable` are both high |
| cfgWe | input | 1 | Load strobe for the configuration byte |
| cfgByte | input | 8 | Configuration: bit 7 is the mode (1 = fast), bits 6..0 are the divider code |
| sclDriveLow | output | 1 | Pull the line low when high; release it when low |
| bitTick | output | 1 | One-cycle pulse on each rising edge of the line |

## Verification
The properties assume that `enable`, `runReq`, `cfgWe` and `cfgByte` are synchronous to `clk` and settle well before each rising edge. They also assume that the configuration byte changes only through `cfgWe`. The bench changes inputs only on falling edges and samples outputs on falling edges. Under the style's configuration every code gives a low part of at least 9 cycles, so the low-part floor property holds for every byte the bench writes, including the clamped codes.

// File: rtl/sclPacerPkg.sv
package sclPacerPkg;

  // Phase of the line pacing sequence
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phaseT;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;    // zero the phase counter
    logic incCnt;    // advance the phase counter
    logic latchLen;  // capture lengths for a new period
  } dpCtrlT;

endpackage

// File: rtl/sclPacerDp.sv
module sclPacerDp
  import sclPacerPkg::*;
#(
  parameter int CODE_W   = 7,
  parameter int STD_OFS  = 9,
  parameter int FAST_OFS = 7,
  parameter int STD_MIN  = 3,
  parameter int FAST_MIN = 2,
  parameter int CNT_W    = CODE_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CODE_W:0]   cfgByte,
  input  dpCtrlT            ctrl,
  output logic [CODE_W:0]   cfgQ,
  output logic [CNT_W-1:0]  countQ,
  output logic              lowDone,
  output logic              highDone
);

  logic              fastSel;
  logic [CNT_W-1:0]  codeExt;
  logic [CNT_W-1:0]  floorVal;
  logic [CNT_W-1:0]  codeEff;
  logic [CNT_W-1:0]  unitLen;
  logic [CNT_W-1:0]  lowNext;
  logic [CNT_W-1:0]  highNext;
  logic [CNT_W-1:0]  lowLen;
  logic [CNT_W-1:0]  highLen;

  // Configuration register: only cfgWe changes it, enable has no say
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgQ <= '0;
    else if (cfgWe) cfgQ <= cfgByte;
  end

  // Clamp the code and compute the phase lengths
  always_comb begin
    fastSel  = cfgQ[CODE_W];
    codeExt  = CNT_W'(cfgQ[CODE_W-1:0]);
    floorVal = fastSel ? CNT_W'(FAST_MIN) : CNT_W'(STD_MIN);
    codeEff  = (codeExt < floorVal) ? floorVal : codeExt;
    unitLen  = codeEff + (fastSel ? CNT_W'(FAST_OFS) : CNT_W'(STD_OFS));
    lowNext  = fastSel ? unitLen : (unitLen << 1);
    highNext = unitLen;
  end

  // Lengths are frozen for the whole period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowLen  <= '0;
      highLen <= '0;
    end else if (ctrl.latchLen) begin
      lowLen  <= lowNext;
      highLen <= highNext;
    end
  end

  // Phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            countQ <= '0;
    else if (ctrl.clrCnt) countQ <= '0;
    else if (ctrl.incCnt) countQ <= countQ + 1'b1;
  end

  assign lowDone  = (countQ == lowLen  - 1'b1);
  assign highDone = (countQ == highLen - 1'b1);

endmodule

// File: rtl/sclPacerCtl.sv
module sclPacerCtl
  import sclPacerPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   active,
  input  logic   lowDone,
  input  logic   highDone,
  output dpCtrlT ctrl,
  output logic   sclDriveLow,
  output logic   bitTick
);

  phaseT phase;
  phaseT phaseNext;
  logic  tickNext;

  always_comb begin
    phaseNext = phase;
    ctrl      = '0;
    if (!active) begin
      phaseNext   = PH_IDLE;
      ctrl.clrCnt = 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phaseNext     = PH_LOW;
          ctrl.clrCnt   = 1'b1;
          ctrl.latchLen = 1'b1;
        end
        PH_LOW: begin
          if (lowDone) begin
            phaseNext   = PH_HIGH;
            ctrl.clrCnt = 1'b1;
          end else begin
            ctrl.incCnt = 1'b1;
          end
        end
        PH_HIGH: begin
          if (highDone) begin
            phaseNext     = PH_LOW;
            ctrl.clrCnt   = 1'b1;
            ctrl.latchLen = 1'b1;
          end else begin
            ctrl.incCnt = 1'b1;
          end
        end
        default: begin
          phaseNext   = PH_IDLE;
          ctrl.clrCnt = 1'b1;
        end
      endcase
    end
  end

  assign tickNext = active && (phase == PH_LOW) && lowDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      bitTick <= 1'b0;
    end else begin
      phase   <= phaseNext;
      bitTick <= tickNext;
    end
  end

  assign sclDriveLow = (phase == PH_LOW);

endmodule

// File: rtl/sclPacer.sv
module sclPacer
  import sclPacerPkg::*;
#(
  parameter int CODE_W   = 7,
  parameter int STD_OFS  = 9,
  parameter int FAST_OFS = 7,
  parameter int STD_MIN  = 3,
  parameter int FAST_MIN = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            runReq,
  input  logic            cfgWe,
  input  logic [CODE_W:0] cfgByte,
  output logic            sclDriveLow,
  output logic            bitTick
);

  localparam int CNT_W = CODE_W + 3;

  dpCtrlT            ctrl;
  logic              active;
  logic              lowDone;
  logic              highDone;
  logic [CODE_W:0]   cfgQ;
  logic [CNT_W-1:0]  countQ;

  assign active = enable & runReq;

  sclPacerDp #(
    .CODE_W  (CODE_W),
    .STD_OFS (STD_OFS),
    .FAST_OFS(FAST_OFS),
    .STD_MIN (STD_MIN),
    .FAST_MIN(FAST_MIN),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgByte (cfgByte),
    .ctrl    (ctrl),
    .cfgQ    (cfgQ),
    .countQ  (countQ),
    .lowDone (lowDone),
    .highDone(highDone)
  );

  sclPacerCtl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .active     (active),
    .lowDone    (lowDone),
    .highDone   (highDone),
    .ctrl       (ctrl),
    .sclDriveLow(sclDriveLow),
    .bitTick    (bitTick)
  );

endmodule

// File: rtl/sclPacerChk.sv
module sclPacerChk #(
  parameter int CODE_W    = 7,
  parameter int CNT_W     = 10,
  parameter int LOW_FLOOR = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             active,
  input logic             cfgWe,
  input logic [CODE_W:0]  cfgQ,
  input logic [CNT_W-1:0] countQ,
  input logic             sclDriveLow,
  input logic             bitTick
);

  logic [CNT_W:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lowRun <= '0;
    else if (sclDriveLow) lowRun <= lowRun + 1'b1;
    else                  lowRun <= '0;
  end

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (!sclDriveLow && !bitTick)); // R7

  AST_CNT_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (countQ == '0)); // R7

  AST_TICK_AT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> (!sclDriveLow && $past(sclDriveLow))); // R8

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> !bitTick); // R8

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(cfgQ)); // R5

  AST_LOW_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> (int'(lowRun) >= LOW_FLOOR)); // R3 R4

endmodule

bind sclPacer sclPacerChk #(
  .CODE_W   (CODE_W),
  .CNT_W    (CNT_W),
  .LOW_FLOOR(FAST_MIN + FAST_OFS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .active     (active),
  .cfgWe      (cfgWe),
  .cfgQ       (cfgQ),
  .countQ     (countQ),
  .sclDriveLow(sclDriveLow),
  .bitTick    (bitTick)
);

// File: tb/sclPacer_tb.sv
module sclPacer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {config byte, expected low cycles, expected released cycles}
  localparam int VEC [NVEC][3] = '{
    '{  0,  24,  12}, '{  1,  24,  12}, '{  3,  24,  12}, '{ 10,  38,  19},
    '{127, 272, 136}, '{128,   9,   9}, '{129,   9,   9}, '{130,   9,   9},
    '{133,  12,  12}, '{255, 134, 134}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       enable;
  logic       runReq;
  logic       cfgWe;
  logic [7:0] cfgByte;
  logic       sclDriveLow;
  logic       bitTick;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sclPacer u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .runReq(runReq),
    .cfgWe(cfgWe), .cfgByte(cfgByte),
    .sclDriveLow(sclDriveLow), .bitTick(bitTick)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [7:0] b);
    cfgWe = 1'b1; cfgByte = b;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Measure one period; optionally write a new byte during the low part
  task automatic measurePeriod(input bit doSync, input bit doWrite,
                               input logic [7:0] wb,
                               output int lo, output int hi,
                               output int tk, output int tkFirst);
    lo = 0; hi = 0; tk = 0; tkFirst = 0;
    if (doSync) begin
      while (sclDriveLow)  @(negedge clk);
      while (!sclDriveLow) @(negedge clk);
    end
    while (sclDriveLow) begin
      lo++;
      if (doWrite && lo == 5) begin cfgWe = 1'b1; cfgByte = wb; end
      else cfgWe = 1'b0;
      @(negedge clk);
    end
    cfgWe = 1'b0;
    while (!sclDriveLow) begin
      if (bitTick) begin
        tk++;
        if (hi == 0) tkFirst = 1;
      end
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int lo, hi, tk, tf, seen;
    string tag;
    rstN = 1'b0; enable = 1'b0; runReq = 1'b0; cfgWe = 1'b0; cfgByte = '0;
    repeat (3) @(negedge clk);
    check("R9 drive low in reset", sclDriveLow, 0);
    check("R9 tick in reset", bitTick, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 drive low after reset", sclDriveLow, 0);

    // Vector table walk
    enable = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      runReq = 1'b0;
      @(negedge clk);
      writeCfg(8'(VEC[i][0]));
      runReq = 1'b1;
      measurePeriod(1'b1, 1'b0, 8'h00, lo, hi, tk, tf);
      if (VEC[i][0] >= 128) tag = (VEC[i][0] - 128 < 2) ? "R4" : "R2";
      else                  tag = (VEC[i][0] < 3) ? "R3" : "R1";
      check({tag, " low length"}, lo, VEC[i][1]);
      check({tag, " released length"}, hi, VEC[i][2]);
      check("R8 ticks per period", tk, 1);
      check("R8 tick on first released cycle", tf, 1);
    end

    // R7: enable low with a request pending keeps the line released
    runReq = 1'b0;
    @(negedge clk);
    enable = 1'b0; runReq = 1'b1;
    seen = 0;
    repeat (50) begin @(negedge clk); if (sclDriveLow || bitTick) seen++; end
    check("R7 disabled line stays released", seen, 0);
    enable = 1'b1; runReq = 1'b0;
    seen = 0;
    repeat (50) begin @(negedge clk); if (sclDriveLow || bitTick) seen++; end
    check("R7 no request line stays released", seen, 0);

    // R5: write while disabled, then toggle enable; byte is kept
    enable = 1'b0;
    writeCfg(8'd133);
    repeat (5) @(negedge clk);
    enable = 1'b1; runReq = 1'b1;
    measurePeriod(1'b1, 1'b0, 8'h00, lo, hi, tk, tf);
    check("R5 written while disabled low", lo, 12);
    check("R5 written while disabled high", hi, 12);
    enable = 1'b0;
    repeat (8) @(negedge clk);
    enable = 1'b1;
    measurePeriod(1'b1, 1'b0, 8'h00, lo, hi, tk, tf);
    check("R5 kept across disable low", lo, 12);
    check("R5 kept across disable high", hi, 12);

    // R6: change during the low part applies from the next period
    runReq = 1'b0;
    @(negedge clk);
    writeCfg(8'd10);
    runReq = 1'b1;
    measurePeriod(1'b1, 1'b1, 8'd133, lo, hi, tk, tf);
    check("R6 current period low kept", lo, 38);
    check("R6 current period high kept", hi, 19);
    measurePeriod(1'b0, 1'b0, 8'h00, lo, hi, tk, tf);
    check("R6 next period low new", lo, 12);
    check("R6 next period high new", hi, 12);

    // R7: dropping the request mid low part, then restart with a full low part
    repeat (4) @(negedge clk);
    check("R7 in low part before drop", sclDriveLow, 1);
    runReq = 1'b0;
    @(negedge clk);
    check("R7 released one cycle after drop", sclDriveLow, 0);
    runReq = 1'b1;
    @(negedge clk);
    check("R7 low again one cycle after request", sclDriveLow, 1);
    measurePeriod(1'b0, 1'b0, 8'h00, lo, hi, tk, tf);
    check("R7 restart full low part", lo, 12);
    check("R8 tick after restart", tk, 1);

    runReq = 1'b0;
    repeat (3) @(negedge clk);
    summary();
  end

endmodule